// File: doc/BRIEF.md
# Interrupt-Capable General-Purpose I/O Port

This block is a 32-pin general-purpose I/O port for a chip's peripheral fabric. Software reaches it through a plain word-addressed register bus: an address, a write strobe, write data, and combinational read data. The port holds the output value and a per-pin output enable. Output bits can be changed one at a time, without a read-modify-write, through a set window and a clear window. Pad inputs pass through a two-flop synchroniser and can be read back.

Each pin has its own interrupt detector, configured by three single-bit fields. The kind bit picks edge or level. The polarity bit picks rising or high (0), or falling or low (1). The dual bit, which only matters for edges, catches both edges. A detection is recorded in a sticky status register only when the pin's enable bit is set. Software clears status by writing ones to a clear window. A mask register keeps recorded status off the single combined interrupt line. Pull-resistor and debounce settings are storage only: they are written and read back and have no effect on the pins.

Top module: `gpio_port`

## Requirements
- R1: After reset every register reads 0, `pad_oe` and `pad_out` are 0, and `irq_out` is low.
- R2: Offset 0x08 holds the output enable, where bit value 1 drives the pin, and `pad_oe` equals it from the cycle after the write. Offset 0x00 holds the output value, which appears on `pad_out` the cycle after the write.
- R3: A write to 0x10 sets each output bit written as 1. A write to 0x14 clears each output bit written as 1. Bits written as 0 keep their value. Both windows read as 0.
- R4: Offset 0x04 returns `pad_in` through two flops. A change set up before clock edge k is readable after edge k+1. Writes to 0x04 have no effect.
- R5: When kind=0 and dual=0, polarity 0 detects a rising edge and polarity 1 detects a falling edge. The status bit sets on the third clock edge after the pad change. Kind is at 0x34, polarity at 0x3C and dual at 0x38, one bit per pin.
- R6: When kind=0 and dual=1, both edges are detected, whatever the polarity bit holds.
- R7: When kind=1, polarity 0 detects a high level and polarity 1 detects a low level. The status bit sets again on every cycle the condition holds.
- R8: A status bit (read at 0x24) is set only while its enable bit (0x20) is 1. Events on pins that are not enabled leave no trace.
- R9: Writing 1s to 0x30 clears the matching status bits. Bits written as 0 are untouched. A detection in the same cycle as a clear wins. Writes to 0x24 have no effect.
- R10: `irq_out` is high exactly when some status bit is 1 and its mask bit (0x2C) is 0. Masking hides status but does not stop it being recorded.
- R11: Offsets 0x18, 0x1C, 0x40 and 0x44 store all 32 bits written and read them back, with no effect on any pin. Unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pad_in | input | 32 | Pad input levels, asynchronous |
| pad_out | output | 32 | Output value to the pads |
| pad_oe | output | 32 | Per-pin output enable |
| irq_out | output | 1 | Combined interrupt request |

## Verification
A wrong bit in the output or enable registers shows on `pad_out` or `pad_oe` in the very next cycle. A wrong trigger configuration, synchroniser delay or edge history appears as an early, late or missing status bit, and so as a wrong `irq_out` level, within three cycles of the pad change. A clear that loses to the wrong side, or a mask that hides too much, shows as an interrupt line level that differs from the expected one on the cycle right after the write. Comparing the outputs against a reference model on every clock therefore places any such fault to within one cycle.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam logic [7:0] OFS_OUT_VAL  = 8'h00;
  localparam logic [7:0] OFS_IN_VAL   = 8'h04;
  localparam logic [7:0] OFS_DRIVE    = 8'h08;
  localparam logic [7:0] OFS_SET      = 8'h10;
  localparam logic [7:0] OFS_CLEAR    = 8'h14;
  localparam logic [7:0] OFS_PULL_ON  = 8'h18;
  localparam logic [7:0] OFS_PULL_DIR = 8'h1C;
  localparam logic [7:0] OFS_IRQ_EN   = 8'h20;
  localparam logic [7:0] OFS_IRQ_STAT = 8'h24;
  localparam logic [7:0] OFS_IRQ_HIDE = 8'h2C;
  localparam logic [7:0] OFS_IRQ_ACK  = 8'h30;
  localparam logic [7:0] OFS_KIND     = 8'h34;
  localparam logic [7:0] OFS_DUAL     = 8'h38;
  localparam logic [7:0] OFS_POL      = 8'h3C;
  localparam logic [7:0] OFS_FILT_ON  = 8'h40;
  localparam logic [7:0] OFS_FILT_DIV = 8'h44;
endpackage

// File: rtl/gpio_port_sync.sv
module gpio_port_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < STAGES; k++) chain[k] <= '0;
    end else begin
      chain[0] <= d;
      for (int k = 1; k < STAGES; k++) chain[k] <= chain[k-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/gpio_port_trig.sv
module gpio_port_trig #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] cur,
  input  logic [N-1:0] kind,
  input  logic [N-1:0] pol,
  input  logic [N-1:0] dual,
  input  logic [N-1:0] en,
  input  logic [N-1:0] clr,
  output logic [N-1:0] status
);
  logic [N-1:0] prev_q;
  logic [N-1:0] status_q;
  logic [N-1:0] lvl_hit;
  logic [N-1:0] edg_hit;
  logic [N-1:0] hit;

  for (genvar g = 0; g < N; g++) begin : g_pin
    assign lvl_hit[g] = cur[g] ^ pol[g];
    assign edg_hit[g] = dual[g] ? (cur[g] ^ prev_q[g])
                                : ((cur[g] ^ pol[g]) & ~(prev_q[g] ^ pol[g]));
    assign hit[g]     = kind[g] ? lvl_hit[g] : edg_hit[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q   <= '0;
      status_q <= '0;
    end else begin
      prev_q   <= cur;
      status_q <= (status_q & ~clr) | (hit & en);
    end
  end

  assign status = status_q;

  // R8: no status bit rises on a pin that was not enabled
  a_r8_only_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status & ~$past(status) & ~$past(en)) == '0));
  // R9: a clear with no competing detection empties the bit
  a_r9_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status & $past(clr) & ~$past(hit & en)) == '0));
  // R7: an active enabled level keeps its bit set
  a_r7_level_holds: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status & $past(lvl_hit & kind & en)) == $past(lvl_hit & kind & en)));
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_port_pkg::*;
#(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [7:0]   bus_addr,
  input  logic         bus_wr,
  input  logic [N-1:0] bus_wdata,
  output logic [N-1:0] bus_rdata,
  input  logic [N-1:0] pad_in,
  output logic [N-1:0] pad_out,
  output logic [N-1:0] pad_oe,
  output logic         irq_out
);
  localparam int SYNC_STAGES = 2;

  logic [N-1:0] out_q, drive_q, pull_on_q, pull_dir_q;
  logic [N-1:0] ien_q, hide_q, kind_q, dual_q, pol_q;
  logic [N-1:0] filt_on_q, filt_div_q;
  logic [N-1:0] pin_sync, stat_w, ack_vec;

  function automatic logic wsel(input logic [7:0] a, input logic [7:0] ofs, input logic w);
    return w && (a == ofs);
  endfunction

  gpio_port_sync #(.W(N), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pad_in), .q(pin_sync)
  );

  assign ack_vec = wsel(bus_addr, OFS_IRQ_ACK, bus_wr) ? bus_wdata : '0;

  gpio_port_trig #(.N(N)) u_trig (
    .clk(clk), .rst_n(rst_n), .cur(pin_sync), .kind(kind_q), .pol(pol_q),
    .dual(dual_q), .en(ien_q), .clr(ack_vec), .status(stat_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '0;
    end else if (wsel(bus_addr, OFS_OUT_VAL, bus_wr)) begin
      out_q <= bus_wdata;
    end else if (wsel(bus_addr, OFS_SET, bus_wr)) begin
      out_q <= out_q | bus_wdata;
    end else if (wsel(bus_addr, OFS_CLEAR, bus_wr)) begin
      out_q <= out_q & ~bus_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drive_q    <= '0;
      pull_on_q  <= '0;
      pull_dir_q <= '0;
      ien_q      <= '0;
      hide_q     <= '0;
      kind_q     <= '0;
      dual_q     <= '0;
      pol_q      <= '0;
      filt_on_q  <= '0;
      filt_div_q <= '0;
    end else if (bus_wr) begin
      case (bus_addr)
        OFS_DRIVE:    drive_q    <= bus_wdata;
        OFS_PULL_ON:  pull_on_q  <= bus_wdata;
        OFS_PULL_DIR: pull_dir_q <= bus_wdata;
        OFS_IRQ_EN:   ien_q      <= bus_wdata;
        OFS_IRQ_HIDE: hide_q     <= bus_wdata;
        OFS_KIND:     kind_q     <= bus_wdata;
        OFS_DUAL:     dual_q     <= bus_wdata;
        OFS_POL:      pol_q      <= bus_wdata;
        OFS_FILT_ON:  filt_on_q  <= bus_wdata;
        OFS_FILT_DIV: filt_div_q <= bus_wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (bus_addr)
      OFS_OUT_VAL:  bus_rdata = out_q;
      OFS_IN_VAL:   bus_rdata = pin_sync;
      OFS_DRIVE:    bus_rdata = drive_q;
      OFS_PULL_ON:  bus_rdata = pull_on_q;
      OFS_PULL_DIR: bus_rdata = pull_dir_q;
      OFS_IRQ_EN:   bus_rdata = ien_q;
      OFS_IRQ_STAT: bus_rdata = stat_w;
      OFS_IRQ_HIDE: bus_rdata = hide_q;
      OFS_KIND:     bus_rdata = kind_q;
      OFS_DUAL:     bus_rdata = dual_q;
      OFS_POL:      bus_rdata = pol_q;
      OFS_FILT_ON:  bus_rdata = filt_on_q;
      OFS_FILT_DIV: bus_rdata = filt_div_q;
      default:      bus_rdata = '0;
    endcase
  end

  assign pad_out = out_q;
  assign pad_oe  = drive_q;
  assign irq_out = |(stat_w & ~hide_q);

  // R2: the enable register lands on the pins one cycle after the write
  a_r2_drive_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == OFS_DRIVE) |=> (pad_oe == $past(bus_wdata)));
  // R3: set window raises every written one
  a_r3_set_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == OFS_SET) |=> ((pad_out & $past(bus_wdata)) == $past(bus_wdata)));
  // R3: clear window drops every written one
  a_r3_clear_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == OFS_CLEAR) |=> ((pad_out & $past(bus_wdata)) == '0));
  // R10: fully masked status never raises the line
  a_r10_hidden_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat_w & ~hide_q) == '0) |-> !irq_out);
endmodule

// File: tb/gpio_port_tb_top.sv
module gpio_port_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] pad_in = '0;
  logic [31:0] pad_out, pad_oe;
  logic        irq_out;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  gpio_port dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .irq_out(irq_out)
  );

  // behavioural reference model
  logic [31:0] m_out, m_dir, m_pe, m_pt, m_ien, m_stat, m_mask;
  logic [31:0] m_kind, m_dual, m_pol, m_de, m_dp, m_s1, m_s2, m_prev;
  logic [31:0] m_hit, m_clr;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_out = 0; m_dir = 0; m_pe = 0; m_pt = 0; m_ien = 0; m_stat = 0; m_mask = 0;
      m_kind = 0; m_dual = 0; m_pol = 0; m_de = 0; m_dp = 0;
      m_s1 = 0; m_s2 = 0; m_prev = 0;
    end else begin
      for (int i = 0; i < 32; i++) begin
        if (m_kind[i])      m_hit[i] = m_pol[i] ? !m_s2[i] : m_s2[i];
        else if (m_dual[i]) m_hit[i] = (m_s2[i] != m_prev[i]);
        else if (m_pol[i])  m_hit[i] = !m_s2[i] && m_prev[i];
        else                m_hit[i] = m_s2[i] && !m_prev[i];
      end
      m_clr  = (bus_wr && bus_addr == 8'h30) ? bus_wdata : 32'h0;
      m_stat = (m_stat & ~m_clr) | (m_hit & m_ien);
      m_prev = m_s2; m_s2 = m_s1; m_s1 = pad_in;
      if (bus_wr) begin
        case (bus_addr)
          8'h00: m_out = bus_wdata;
          8'h08: m_dir = bus_wdata;
          8'h10: m_out = m_out | bus_wdata;
          8'h14: m_out = m_out & ~bus_wdata;
          8'h18: m_pe = bus_wdata;
          8'h1C: m_pt = bus_wdata;
          8'h20: m_ien = bus_wdata;
          8'h2C: m_mask = bus_wdata;
          8'h34: m_kind = bus_wdata;
          8'h38: m_dual = bus_wdata;
          8'h3C: m_pol = bus_wdata;
          8'h40: m_de = bus_wdata;
          8'h44: m_dp = bus_wdata;
          default: ;
        endcase
      end
    end
  end

  function automatic logic [31:0] mread(input logic [7:0] a);
    case (a)
      8'h00: return m_out;   8'h04: return m_s2;   8'h08: return m_dir;
      8'h18: return m_pe;    8'h1C: return m_pt;   8'h20: return m_ien;
      8'h24: return m_stat;  8'h2C: return m_mask; 8'h34: return m_kind;
      8'h38: return m_dual;  8'h3C: return m_pol;  8'h40: return m_de;
      8'h44: return m_dp;    default: return 32'h0;
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // every-cycle comparison of the pins against the model
  always @(negedge clk) begin
    if (rst_n) begin
      check("R2 pad_oe", pad_oe, m_dir);
      check("R3 pad_out", pad_out, m_out);
      check("R10 irq_out", {31'h0, irq_out}, {31'h0, |(m_stat & ~m_mask)});
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_exp(input string tag, input logic [7:0] a, input logic [31:0] exp);
    bus_addr = a;
    #1;
    check(tag, bus_rdata, exp);
    check({tag, " model"}, bus_rdata, mread(a));
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog all-R actual=running expected=finished");
      finish_run();
    end
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    // R1 reset state
    rd_exp("R1 out reset", 8'h00, 32'h0);
    rd_exp("R1 drive reset", 8'h08, 32'h0);
    rd_exp("R1 status reset", 8'h24, 32'h0);
    check("R1 irq reset", {31'h0, irq_out}, 32'h0);
    // R2 drive and output value
    wr(8'h08, 32'h0000FFFF);
    wr(8'h00, 32'hA5A5A5A5);
    rd_exp("R2 out value", 8'h00, 32'hA5A5A5A5);
    rd_exp("R2 drive value", 8'h08, 32'h0000FFFF);
    // R3 atomic set/clear
    wr(8'h10, 32'h0000000F);
    rd_exp("R3 set", 8'h00, 32'hA5A5A5AF);
    wr(8'h14, 32'hA0000000);
    rd_exp("R3 clear", 8'h00, 32'h05A5A5AF);
    rd_exp("R3 set window reads 0", 8'h10, 32'h0);
    rd_exp("R3 clear window reads 0", 8'h14, 32'h0);
    // R4 synchronised input
    pad_in = 32'h12345678;
    tick(1);
    rd_exp("R4 not yet", 8'h04, 32'h0);
    tick(1);
    rd_exp("R4 arrived", 8'h04, 32'h12345678);
    wr(8'h04, 32'hFFFFFFFF);
    rd_exp("R4 write ignored", 8'h04, 32'h12345678);
    // trigger setup: pin0 rise, pin1 fall, pin2 both, pin3 high, pin4 low, pin5 disabled
    pad_in = 32'h00000012;
    tick(4);
    wr(8'h34, 32'h00000018);
    wr(8'h3C, 32'h00000016);
    wr(8'h38, 32'h00000004);
    wr(8'h20, 32'h0000001F);
    wr(8'h30, 32'hFFFFFFFF);
    rd_exp("R9 all cleared", 8'h24, 32'h0);
    // R5 rising, timing
    pad_in[0] = 1'b1;
    tick(2);
    rd_exp("R5 rise not yet", 8'h24, 32'h0);
    tick(1);
    rd_exp("R5 rise caught", 8'h24, 32'h1);
    wr(8'h30, 32'h1);
    rd_exp("R9 clear rise", 8'h24, 32'h0);
    // R5 falling
    pad_in[1] = 1'b0;
    tick(3);
    rd_exp("R5 fall caught", 8'h24, 32'h2);
    wr(8'h30, 32'h2);
    // R6 both edges
    pad_in[2] = 1'b1;
    tick(3);
    rd_exp("R6 both rise", 8'h24, 32'h4);
    wr(8'h30, 32'h4);
    pad_in[2] = 1'b0;
    tick(3);
    rd_exp("R6 both fall", 8'h24, 32'h4);
    wr(8'h30, 32'h4);
    // R8 disabled pin
    pad_in[5] = 1'b1;
    tick(4);
    rd_exp("R8 disabled silent", 8'h24, 32'h0);
    // R7 high level, R9 detection beats clear
    pad_in[3] = 1'b1;
    tick(3);
    rd_exp("R7 high caught", 8'h24, 32'h8);
    wr(8'h30, 32'h8);
    rd_exp("R9 level re-sets over clear", 8'h24, 32'h8);
    wr(8'h24, 32'h0);
    rd_exp("R9 status write ignored", 8'h24, 32'h8);
    pad_in[3] = 1'b0;
    tick(3);
    wr(8'h30, 32'h8);
    rd_exp("R7 level gone", 8'h24, 32'h0);
    // R7 low level, R10 mask
    pad_in[4] = 1'b0;
    tick(3);
    rd_exp("R7 low caught", 8'h24, 32'h10);
    check("R10 irq raised", {31'h0, irq_out}, 32'h1);
    wr(8'h2C, 32'h10);
    check("R10 irq masked", {31'h0, irq_out}, 32'h0);
    rd_exp("R10 status kept", 8'h24, 32'h10);
    wr(8'h2C, 32'h0);
    check("R10 irq unmasked", {31'h0, irq_out}, 32'h1);
    pad_in[4] = 1'b1;
    tick(3);
    wr(8'h30, 32'h10);
    rd_exp("R9 final clear", 8'h24, 32'h0);
    // R11 storage-only registers
    wr(8'h18, 32'hDEADBEEF);
    wr(8'h1C, 32'h0BADF00D);
    wr(8'h40, 32'h13579BDF);
    wr(8'h44, 32'h2468ACE0);
    rd_exp("R11 pull on", 8'h18, 32'hDEADBEEF);
    rd_exp("R11 pull dir", 8'h1C, 32'h0BADF00D);
    rd_exp("R11 filter on", 8'h40, 32'h13579BDF);
    rd_exp("R11 filter div", 8'h44, 32'h2468ACE0);
    rd_exp("R11 unmapped", 8'h48, 32'h0);
    rd_exp("R11 pins untouched", 8'h00, 32'h05A5A5AF);
    tick(2);
    done = 1;
    finish_run();
  end
endmodule